// File: doc/BRIEF.md
# FIFO Watermark Data-Request and Interrupt Logic

This block sits beside the byte FIFO of a two-wire serial bus controller. It decides when the host should move data into or out of that FIFO, and it raises a single interrupt line when an enabled condition is present. Its inputs are the transfer direction, the FIFO occupancy and two residual byte counters. One counter holds the bytes still to cross the serial bus. The other holds the bytes the host still has to push or pull. It also takes the stop flag of the active command and the busy state of the selected bus. From these it keeps four registered flags: data request, command complete, high water and low water. The status word, the interrupt conditions and the interrupt line all come from these flags.

A small write port holds the configuration. It sets the programmable high and low watermarks, and it updates the interrupt enable mask in one of three ways: direct load, bitwise OR-set or bitwise AND-clear. When a command finishes and carries a stop, the block pulses an end-of-transfer request toward the bus engine and drops its two busy bits. The FIFO storage and the wire protocol lie outside this block.

Every flag is registered. Each one changes at the clock edge that follows the input change that caused it. The raw condition, the masked condition and the interrupt line follow the registered flags and the mask without a further delay.

Top module: `wm_dreq_irq`

## Requirements
- R1: After reset the status word is 32'h0001_0000: only the command-complete flag (bit 16) is set, and the busy bits (bits 1:0) are clear. The mask and both watermarks are zero, and `irq` and `end_xfer` are low.
- R2: While `bus_busy` is low, the four flags (status bits 19:16) keep their values and `end_xfer` stays low.
- R3: On a read (`rd_dir`=1) with the bus busy, high water (bit 18) becomes 1 when `fifo_cnt` ≥ the high watermark and 0 otherwise. Low water (bit 19) keeps its value.
- R4: On a read with the bus busy, and unless both residuals are zero, data request (bit 17) becomes 1 when high water is set and the FIFO is not empty, or when `bus_res` is zero. Otherwise it becomes 0.
- R5: On a write (`rd_dir`=0) with the bus busy, low water becomes 1 when `fifo_cnt` ≤ the low watermark and 0 otherwise. High water keeps its value.
- R6: On a write with the bus busy, and unless both residuals are zero, data request becomes 1 when `host_res` is non-zero and either the free space (DEPTH − `fifo_cnt`) is at least `host_res` or low water is set. Otherwise it becomes 0.
- R7: With the bus busy and both residuals zero, data request becomes 0 and command complete becomes 1. If `stop_req` is also high, `end_xfer` is high for the next cycle and both busy bits clear. Without the stop, the busy bits keep their values.
- R8: With the bus busy and either residual non-zero, command complete becomes 0.
- R9: `irq_raw` equals status bits 31:16, so bit 0 is command complete, bit 1 data request, bit 2 high water and bit 3 low water. `irq_masked` is `irq_raw` AND `irq_mask`, and `irq` is high exactly when `irq_masked` is non-zero.
- R10: A write to address 0 loads the mask from `wr_data`, address 1 ORs `wr_data` into it, and address 2 ANDs it with `wr_data`. The new mask takes effect after the write edge.
- R11: A write to address 3 loads the low watermark from `wr_data[7:0]` and the high watermark from `wr_data[15:8]`. A `xfer_start` pulse sets both busy bits, and it wins over a stop-driven clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_busy | input | 1 | Selected serial bus holds an active transfer |
| rd_dir | input | 1 | Direction of the active command, 1 = read |
| stop_req | input | 1 | Active command ends with a stop |
| xfer_start | input | 1 | Pulse: a command has started, set busy bits |
| fifo_cnt | input | CNT_W (4) | FIFO occupancy, 0..DEPTH |
| bus_res | input | RES_W (16) | Bytes still to cross the serial bus |
| host_res | input | RES_W (16) | Bytes still to be moved by the host |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 2 | 0 mask load, 1 mask OR, 2 mask AND, 3 watermarks |
| wr_data | input | WR_W (16) | Configuration write data |
| stat_word | output | 32 | Status word: flags in 19:16, busy bits in 1:0 |
| irq_raw | output | 16 | Raw interrupt condition |
| irq_masked | output | 16 | Raw condition AND mask |
| irq_mask | output | 16 | Current interrupt enable mask |
| end_xfer | output | 1 | One-cycle request to end the bus transfer |
| irq | output | 1 | Interrupt line |

## Verification
On every cycle the assertions check several rules that hold regardless of the stimulus. The flags hold while the bus is idle. Command complete and data request are never set together. Completion with both residuals zero sets command complete, and a stop also raises `end_xfer` and clears the busy bits. A write with nothing left for the host never requests data. Each of the three mask update forms gives its own result. The data-request formulas depend on the watermark values and on the direction, so only the bench scenarios can show them. These scenarios include free space just equal to the host residual, a zero high watermark over an empty FIFO, a watermark change that takes effect one cycle late, and low water held across a read.

// File: rtl/wm_pkg.sv
package wm_pkg;

  // Flag set kept by the evaluator; bit 0 lands on status bit 16.
  typedef struct packed {
    logic lo_water;
    logic hi_water;
    logic data_req;
    logic cmd_done;
  } wm_flags_t;

  localparam int unsigned FLAG_N = 4;

  // Configuration write addresses.
  localparam logic [1:0] A_MASK_LD  = 2'd0;
  localparam logic [1:0] A_MASK_OR  = 2'd1;
  localparam logic [1:0] A_MASK_AND = 2'd2;
  localparam logic [1:0] A_WMARK    = 2'd3;

  function automatic int unsigned free_slots(input int unsigned depth,
                                             input int unsigned cnt);
    return (cnt >= depth) ? 0 : depth - cnt;
  endfunction

  function automatic logic at_or_above(input int unsigned cnt,
                                       input int unsigned mark);
    return cnt >= mark;
  endfunction

  function automatic logic at_or_below(input int unsigned cnt,
                                       input int unsigned mark);
    return cnt <= mark;
  endfunction

  // Read side: drain when full enough and not empty, or when the bus is done.
  function automatic logic rd_wants_data(input logic hi,
                                         input int unsigned cnt,
                                         input int unsigned bus_left);
    return (hi && cnt != 0) || (bus_left == 0);
  endfunction

  // Write side: refill when host bytes remain and they fit, or when low.
  function automatic logic wr_wants_data(input int unsigned host_left,
                                         input int unsigned room,
                                         input logic lo);
    return (host_left != 0) && ((room >= host_left) || lo);
  endfunction

endpackage

// File: rtl/wm_cfg_regs.sv
module wm_cfg_regs
  import wm_pkg::*;
#(
  parameter int unsigned WR_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [WR_W-1:0] wr_data,
  output logic [WR_W-1:0] mask_q,
  output logic [WR_W/2-1:0] hi_mark,
  output logic [WR_W/2-1:0] lo_mark
);

  localparam int unsigned HALF = WR_W / 2;

  logic [WR_W-1:0] mask_nxt;
  logic            wm_load;

  always_comb begin
    mask_nxt = mask_q;
    wm_load  = 1'b0;
    if (wr_en) begin
      unique case (wr_addr)
        A_MASK_LD:  mask_nxt = wr_data;
        A_MASK_OR:  mask_nxt = mask_q | wr_data;
        A_MASK_AND: mask_nxt = mask_q & wr_data;
        default:    wm_load  = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      hi_mark <= '0;
      lo_mark <= '0;
    end else begin
      mask_q <= mask_nxt;
      if (wm_load) begin
        lo_mark <= wr_data[HALF-1:0];
        hi_mark <= wr_data[WR_W-1:HALF];
      end
    end
  end

  a_r10_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_MASK_LD) |=> (mask_q == $past(wr_data)));

  a_r10_mask_or: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_MASK_OR) |=> (mask_q == ($past(mask_q) | $past(wr_data))));

  a_r10_mask_and: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_MASK_AND) |=> (mask_q == ($past(mask_q) & $past(wr_data))));

  a_r11_wmark_only_on_addr3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == A_WMARK) |=> ($stable(hi_mark) && $stable(lo_mark)));

endmodule

// File: rtl/wm_flag_eval.sv
module wm_flag_eval
  import wm_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned RES_W = 16,
  parameter int unsigned WM_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_busy,
  input  logic             rd_dir,
  input  logic             stop_req,
  input  logic             xfer_start,
  input  logic [CNT_W-1:0] fifo_cnt,
  input  logic [RES_W-1:0] bus_res,
  input  logic [RES_W-1:0] host_res,
  input  logic [WM_W-1:0]  hi_mark,
  input  logic [WM_W-1:0]  lo_mark,
  output wm_flags_t        flags_q,
  output logic [1:0]       busy_q,
  output logic             end_xfer_q
);

  wm_flags_t   flags_nxt;
  logic [1:0]  busy_nxt;
  logic        end_nxt;
  logic        both_zero;
  int unsigned room;

  assign both_zero = (bus_res == '0) && (host_res == '0);
  assign room      = free_slots(DEPTH, 32'(fifo_cnt));

  always_comb begin
    flags_nxt = flags_q;
    busy_nxt  = busy_q;
    end_nxt   = 1'b0;
    if (bus_busy) begin
      flags_nxt.data_req = 1'b0;
      if (rd_dir) begin
        flags_nxt.hi_water = at_or_above(32'(fifo_cnt), 32'(hi_mark));
        flags_nxt.data_req = rd_wants_data(flags_nxt.hi_water, 32'(fifo_cnt),
                                           32'(bus_res));
      end else begin
        flags_nxt.lo_water = at_or_below(32'(fifo_cnt), 32'(lo_mark));
        flags_nxt.data_req = wr_wants_data(32'(host_res), room,
                                           flags_nxt.lo_water);
      end
      if (both_zero) begin
        flags_nxt.data_req = 1'b0;
        flags_nxt.cmd_done = 1'b1;
        if (stop_req) begin
          end_nxt  = 1'b1;
          busy_nxt = 2'b00;
        end
      end else begin
        flags_nxt.cmd_done = 1'b0;
      end
    end
    if (xfer_start) busy_nxt = 2'b11;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q    <= '{lo_water: 1'b0, hi_water: 1'b0, data_req: 1'b0, cmd_done: 1'b1};
      busy_q     <= 2'b00;
      end_xfer_q <= 1'b0;
    end else begin
      flags_q    <= flags_nxt;
      busy_q     <= busy_nxt;
      end_xfer_q <= end_nxt;
    end
  end

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_busy |=> ($stable(flags_q) && !end_xfer_q));

  a_r7_done_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && both_zero) |=> (flags_q.cmd_done && !flags_q.data_req));

  a_r7_stop_ends_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && both_zero && stop_req && !xfer_start) |=> (end_xfer_q && busy_q == 2'b00));

  a_r8_not_done_with_residue: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && !both_zero) |=> !flags_q.cmd_done);

  a_r6_no_write_req_without_host_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && !rd_dir && host_res == '0) |=> !flags_q.data_req);

  a_r4_read_req_on_bus_done: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && rd_dir && bus_res == '0 && host_res != '0) |=> flags_q.data_req);

  a_r7_req_and_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags_q.data_req && flags_q.cmd_done));

  a_r11_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> (busy_q == 2'b11));

endmodule

// File: rtl/wm_irq_combine.sv
module wm_irq_combine #(
  parameter int unsigned STAT_W = 32,
  parameter int unsigned SHIFT  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [STAT_W-1:0]       stat,
  input  logic [STAT_W-SHIFT-1:0] mask,
  output logic [STAT_W-SHIFT-1:0] raw,
  output logic [STAT_W-SHIFT-1:0] masked,
  output logic                    irq
);

  localparam int unsigned RAW_W = STAT_W - SHIFT;

  assign raw = stat[STAT_W-1:SHIFT];

  for (genvar b = 0; b < RAW_W; b++) begin : g_gate
    assign masked[b] = raw[b] & mask[b];
  end

  assign irq = |masked;

  a_r9_irq_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat[STAT_W-1:SHIFT] != '0));

  a_r9_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask != '0));

endmodule

// File: rtl/wm_dreq_irq.sv
module wm_dreq_irq
  import wm_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1),
  parameter int unsigned RES_W = 16,
  parameter int unsigned WR_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_busy,
  input  logic             rd_dir,
  input  logic             stop_req,
  input  logic             xfer_start,
  input  logic [CNT_W-1:0] fifo_cnt,
  input  logic [RES_W-1:0] bus_res,
  input  logic [RES_W-1:0] host_res,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [WR_W-1:0]  wr_data,
  output logic [31:0]      stat_word,
  output logic [15:0]      irq_raw,
  output logic [15:0]      irq_masked,
  output logic [15:0]      irq_mask,
  output logic             end_xfer,
  output logic             irq
);

  localparam int unsigned STAT_W = 32;
  localparam int unsigned SHIFT  = 16;
  localparam int unsigned RAW_W  = STAT_W - SHIFT;
  localparam int unsigned WM_W   = WR_W / 2;

  logic [WR_W-1:0] mask_q;
  logic [WM_W-1:0] hi_mark;
  logic [WM_W-1:0] lo_mark;
  wm_flags_t       flags_q;
  logic [1:0]      busy_q;
  logic [RAW_W-1:0] mask_fit;

  wm_cfg_regs #(.WR_W(WR_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .mask_q  (mask_q),
    .hi_mark (hi_mark),
    .lo_mark (lo_mark)
  );

  wm_flag_eval #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .RES_W (RES_W),
    .WM_W  (WM_W)
  ) u_eval (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_busy   (bus_busy),
    .rd_dir     (rd_dir),
    .stop_req   (stop_req),
    .xfer_start (xfer_start),
    .fifo_cnt   (fifo_cnt),
    .bus_res    (bus_res),
    .host_res   (host_res),
    .hi_mark    (hi_mark),
    .lo_mark    (lo_mark),
    .flags_q    (flags_q),
    .busy_q     (busy_q),
    .end_xfer_q (end_xfer)
  );

  always_comb begin
    stat_word = '0;
    stat_word[SHIFT +: FLAG_N] = flags_q;
    stat_word[1:0] = busy_q;
  end

  assign mask_fit = RAW_W'(mask_q);

  wm_irq_combine #(.STAT_W(STAT_W), .SHIFT(SHIFT)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .stat   (stat_word),
    .mask   (mask_fit),
    .raw    (irq_raw),
    .masked (irq_masked),
    .irq    (irq)
  );

  assign irq_mask = 16'(mask_q);

  a_r7_end_pulse_only_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    end_xfer |-> $past(bus_busy));

endmodule

// File: tb/tb_wm_dreq_irq.sv
module tb_wm_dreq_irq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_busy, rd_dir, stop_req, xfer_start;
  logic [3:0]  fifo_cnt;
  logic [15:0] bus_res, host_res;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic [31:0] stat_word;
  logic [15:0] irq_raw, irq_masked, irq_mask;
  logic        end_xfer, irq;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  wm_dreq_irq dut (
    .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .rd_dir(rd_dir),
    .stop_req(stop_req), .xfer_start(xfer_start), .fifo_cnt(fifo_cnt),
    .bus_res(bus_res), .host_res(host_res), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .stat_word(stat_word), .irq_raw(irq_raw),
    .irq_masked(irq_masked), .irq_mask(irq_mask), .end_xfer(end_xfer), .irq(irq)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // flags nibble order: {lo_water, hi_water, data_req, cmd_done}
  task automatic drive(input logic busy, input logic rd, input logic stp,
                       input logic [3:0] cnt, input logic [15:0] br,
                       input logic [15:0] hr);
    bus_busy = busy; rd_dir = rd; stop_req = stp;
    fifo_cnt = cnt; bus_res = br; host_res = hr;
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "status", stat_word, 32'h0001_0000);
    chk("R1", "mask", {16'h0, irq_mask}, 32'h0);
    chk("R1", "irq/end", {30'h0, irq, end_xfer}, 32'h0);
  endtask

  task automatic t_idle_hold();
    drive(1'b0, 1'b1, 1'b1, 4'd8, 16'd0, 16'd0);
    step(); step();
    chk("R2", "flags idle", stat_word, 32'h0001_0000);
    chk("R2", "end idle", {31'h0, end_xfer}, 32'h0);
  endtask

  task automatic t_start();
    cfg_write(2'd3, 16'h0402); // R11: hi=4, lo=2
    xfer_start = 1'b1;
    step();
    xfer_start = 1'b0;
    chk("R11", "busy bits", {30'h0, stat_word[1:0]}, 32'h3);
  endtask

  task automatic t_read();
    drive(1'b1, 1'b1, 1'b0, 4'd5, 16'd3, 16'd3); step();
    chk("R3", "read above high mark", {28'h0, stat_word[19:16]}, 32'h6);
    drive(1'b1, 1'b1, 1'b0, 4'd3, 16'd3, 16'd3); step();
    chk("R4", "read below high mark", {28'h0, stat_word[19:16]}, 32'h0);
    drive(1'b1, 1'b1, 1'b0, 4'd0, 16'd0, 16'd2); step();
    chk("R4", "read bus residual zero", {28'h0, stat_word[19:16]}, 32'h2);
    chk("R8", "not complete", {31'h0, stat_word[16]}, 32'h0);
  endtask

  task automatic t_write();
    drive(1'b1, 1'b0, 1'b0, 4'd6, 16'd3, 16'd3); step();
    chk("R6", "write no room", {28'h0, stat_word[19:16]}, 32'h0);
    drive(1'b1, 1'b0, 1'b0, 4'd6, 16'd3, 16'd2); step();
    chk("R6", "write room equals residual", {28'h0, stat_word[19:16]}, 32'h2);
    drive(1'b1, 1'b0, 1'b0, 4'd1, 16'd3, 16'd5); step();
    chk("R5", "write low water", {28'h0, stat_word[19:16]}, 32'hA);
    drive(1'b1, 1'b0, 1'b0, 4'd7, 16'd3, 16'd5); step();
    chk("R5", "write above low mark", {28'h0, stat_word[19:16]}, 32'h0);
    cfg_write(2'd3, 16'h0407); // lo=7: evaluation in that cycle still saw lo=2
    chk("R11", "old low mark still used", {28'h0, stat_word[19:16]}, 32'h0);
    step();
    chk("R5", "new low mark", {28'h0, stat_word[19:16]}, 32'hA);
    drive(1'b1, 1'b0, 1'b0, 4'd7, 16'd3, 16'd0); step();
    chk("R6", "no host bytes", {28'h0, stat_word[19:16]}, 32'h8);
  endtask

  task automatic t_read_keeps_low();
    drive(1'b1, 1'b1, 1'b0, 4'd0, 16'd2, 16'd1); step();
    chk("R3", "low water held on read", {28'h0, stat_word[19:16]}, 32'h8);
    cfg_write(2'd3, 16'h0007); // hi=0
    step();
    chk("R4", "high set, fifo empty", {28'h0, stat_word[19:16]}, 32'hC);
  endtask

  task automatic t_done();
    drive(1'b1, 1'b1, 1'b0, 4'd0, 16'd0, 16'd0); step();
    chk("R7", "done no stop", {28'h0, stat_word[19:16]}, 32'hD);
    chk("R7", "busy kept", {30'h0, stat_word[1:0]}, 32'h3);
    chk("R7", "no end req", {31'h0, end_xfer}, 32'h0);
    stop_req = 1'b1; step();
    chk("R7", "end req", {31'h0, end_xfer}, 32'h1);
    chk("R7", "busy cleared", {30'h0, stat_word[1:0]}, 32'h0);
    drive(1'b0, 1'b1, 1'b1, 4'd0, 16'd0, 16'd0); step();
    chk("R7", "end req one cycle", {31'h0, end_xfer}, 32'h0);
    chk("R2", "flags held after", {28'h0, stat_word[19:16]}, 32'hD);
  endtask

  task automatic t_mask();
    cfg_write(2'd0, 16'h000F);
    chk("R10", "mask load", {16'h0, irq_mask}, 32'h000F);
    cfg_write(2'd1, 16'h0010);
    chk("R10", "mask or", {16'h0, irq_mask}, 32'h001F);
    cfg_write(2'd2, 16'h0003);
    chk("R10", "mask and", {16'h0, irq_mask}, 32'h0003);
  endtask

  task automatic t_irq();
    chk("R9", "raw", {16'h0, irq_raw}, 32'h000D);
    chk("R9", "masked", {16'h0, irq_masked}, 32'h0001);
    chk("R9", "irq on", {31'h0, irq}, 32'h1);
    cfg_write(2'd0, 16'h0002);
    chk("R9", "irq off", {31'h0, irq}, 32'h0);
    cfg_write(2'd1, 16'h0008);
    chk("R9", "irq low water", {31'h0, irq}, 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; xfer_start = 1'b0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = 16'h0;
    drive(1'b0, 1'b0, 1'b0, 4'd0, 16'd0, 16'd0);
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_idle_hold();
    t_start();
    t_read();
    t_write();
    t_read_keeps_low();
    t_done();
    t_mask();
    t_irq();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule